// File: doc/BRIEF.md
# GPS one-pulse-per-second phase offset detector

This block measures how far the rising edge of an external GPS one-pulse-per-second reference sits from a local one-pulse-per-second pulse. The local pulse comes from dividing down the oscillator. The reference is asynchronous to the block. The block runs on a fast clock of nominally 160 MHz, which is the 10 MHz oscillator multiplied by 16. An enable strobe marks each cycle of the 10 MHz oscillator. The divider counts those strobes and emits the local pulse once per second. The offset is counted in fast-clock ticks of 6.25 ns.

The reference first passes through a multi-flop synchronizer and an edge detector. The delay of the synchronizer is known, so it is taken back out of the result. The result is a signed phase error. It is positive when the GPS edge comes after the local edge and negative when it comes before. Whichever edge arrives first in a half-second window sets the sign.

A valid strobe flags each new error value for a downstream loop filter. A missing-reference flag rises when the GPS edge stays away for one and a half seconds. A one-shot alignment request moves the local divider onto the next GPS edge, for coarse alignment at start-up.

Top module: `gps_pps_phase_detector`

## Requirements
- R1: With no alignment pending, `local_pps` is high for exactly one cycle on every DIV_COUNT-th clock edge at which `osc_en` is sampled high. Consecutive pulses are therefore DIV_COUNT strobes apart, which is DIV_COUNT*TICKS_PER_EN cycles when the strobe repeats every TICKS_PER_EN cycles.
- R2: While `rst` is high, `local_pps`, `err_valid` and `pps_missing` are low. After release, the divider counts strobes from zero.
- R3: Let G be the first clock edge at which `gps_pps_in` is sampled high, and L the clock edge that sets `local_pps`. `phase_err` is G - L as a 32-bit two's complement number. It is positive when the GPS edge lags the local edge.
- R4: When the GPS edge leads the local edge, the same G - L formula applies and the value is negative. This includes the case where the synchronized GPS edge and the local pulse fall in the same cycle, which gives -(SYNC_STAGES-1).
- R5: For each matched pair of edges, `err_valid` is high for exactly one cycle. That cycle is one cycle after the later of the local pulse and the synchronized GPS edge, which is edge G+SYNC_STAGES-1. `phase_err` holds its value between reports.
- R6: An edge opens a pairing window. The window closes unmatched if the other edge does not arrive within HALF = DIV_COUNT*TICKS_PER_EN/2 cycles of it, and no report is made for it.
- R7: With no further GPS edge, `pps_missing` goes high at clock edge G + SYNC_STAGES + MISS. Here MISS is three halves of a second in ticks. The flag stays high until the next GPS edge clears it.
- R8: While the GPS reference is absent, local pulses keep running and `err_valid` never rises.
- R9: A one-cycle `align_load` arms realignment. At the next GPS edge, `local_pps` rises at clock edge G+SYNC_STAGES and the divider restarts from zero. The next local pulse then comes on the DIV_COUNT-th strobe after that edge, and the realignment second reports -SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast measurement clock (oscillator times 16) |
| rst | input | 1 | Synchronous active-high reset |
| gps_pps_in | input | 1 | Asynchronous GPS one-pulse-per-second reference |
| osc_en | input | 1 | One-cycle strobe per oscillator cycle |
| align_load | input | 1 | Arms realignment of the divider to the next GPS edge |
| local_pps | output | 1 | Local one-cycle second pulse |
| phase_err | output | 32 | Signed phase error in clock ticks |
| err_valid | output | 1 | One-cycle strobe marking a new phase error |
| pps_missing | output | 1 | GPS reference absent for 1.5 s |

## Verification
The bench builds the block with DIV_COUNT=50, TICKS_PER_EN=4 and two synchronizer stages. A second then shrinks to 200 cycles, the half-second window to 100 and the missing limit to 300. At these sizes, dozens of seconds with random offsets can run, along with the leading and lagging extremes near ±90 ticks, the missing-reference timeout and its recovery, and a realignment that restarts the divider. The bench checks every result against the edge cycles it drove itself.

// File: rtl/gpsphase_pkg.sv
package gpsphase_pkg;

    localparam int ERR_W = 32;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_LOCAL_LEAD,
        MS_GPS_LEAD
    } meas_state_e;

    typedef struct packed {
        logic                    valid;
        logic signed [ERR_W-1:0] err;
    } phase_rpt_t;

    // Signed error from a tick distance: lag gives +mag, lead gives -mag,
    // then the fixed synchronizer latency is removed.
    function automatic logic signed [ERR_W-1:0] form_err(
        input logic             gps_lags,
        input logic [ERR_W-1:0] mag,
        input logic [ERR_W-1:0] lat
    );
        logic signed [ERR_W-1:0] s;
        s = gps_lags ? $signed(mag) : -$signed(mag);
        return s - $signed(lat);
    endfunction

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_async,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], pps_async};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pps_local_div.sv
module pps_local_div #(
    parameter int DIV_COUNT = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    input  logic align_load,
    input  logic gps_rise,
    output logic local_pps
);
    localparam int CW = $clog2(DIV_COUNT);
    localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          pps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            pps_q   <= 1'b0;
        end else begin
            pps_q <= 1'b0;
            if (armed_q && gps_rise) begin
                cnt_q   <= '0;
                pps_q   <= 1'b1;
                armed_q <= align_load;
            end else begin
                if (align_load) armed_q <= 1'b1;
                if (osc_en) begin
                    if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        pps_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign local_pps = pps_q;

    // R1
    lpps_onecycle_chk: assert property (@(posedge clk) disable iff (rst)
        local_pps |=> !local_pps);

    // R9
    realign_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && gps_rise) |=> local_pps);

endmodule

// File: rtl/pps_phase_meter.sv
module pps_phase_meter
    import gpsphase_pkg::*;
#(
    parameter int HALF_TICKS = 80_000_000,
    parameter int LAT        = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    gps_evt,
    input  logic                    local_evt,
    output logic signed [ERR_W-1:0] phase_err,
    output logic                    err_valid
);
    localparam int CW = $clog2(HALF_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HALF_TICKS);
    localparam logic [ERR_W-1:0] LATV = ERR_W'(LAT);
    localparam int ERR_HI = HALF_TICKS - LAT;
    localparam int ERR_LO = -HALF_TICKS - LAT;

    meas_state_e   st_q;
    logic [CW-1:0] cnt_q;
    phase_rpt_t    rpt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= MS_IDLE;
            cnt_q <= '0;
            rpt_q <= '0;
        end else begin
            rpt_q.valid <= 1'b0;
            unique case (st_q)
                MS_IDLE: begin
                    if (gps_evt && local_evt) begin
                        rpt_q.valid <= 1'b1;
                        rpt_q.err   <= form_err(1'b1, '0, LATV);
                    end else if (local_evt) begin
                        st_q  <= MS_LOCAL_LEAD;
                        cnt_q <= CW'(1);
                    end else if (gps_evt) begin
                        st_q  <= MS_GPS_LEAD;
                        cnt_q <= CW'(1);
                    end
                end
                MS_LOCAL_LEAD: begin
                    if (gps_evt) begin
                        rpt_q.valid <= 1'b1;
                        rpt_q.err   <= form_err(1'b1, ERR_W'(cnt_q), LATV);
                        st_q        <= MS_IDLE;
                    end else if (local_evt) begin
                        cnt_q <= CW'(1);
                    end else if (cnt_q == LIMIT) begin
                        st_q <= MS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                MS_GPS_LEAD: begin
                    if (local_evt) begin
                        rpt_q.valid <= 1'b1;
                        rpt_q.err   <= form_err(1'b0, ERR_W'(cnt_q), LATV);
                        st_q        <= MS_IDLE;
                    end else if (gps_evt) begin
                        cnt_q <= CW'(1);
                    end else if (cnt_q == LIMIT) begin
                        st_q <= MS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= MS_IDLE;
            endcase
        end
    end

    assign phase_err = rpt_q.err;
    assign err_valid = rpt_q.valid;

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);

    // R6
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (phase_err <= ERR_HI && phase_err >= ERR_LO));

    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !err_valid |=> (err_valid || $stable(phase_err)));

endmodule

// File: rtl/pps_loss_watch.sv
module pps_loss_watch #(
    parameter int MISS_TICKS = 240_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic gps_evt,
    output logic pps_missing
);
    localparam int CW = $clog2(MISS_TICKS + 1);
    localparam logic [CW-1:0] SAT  = CW'(MISS_TICKS);
    localparam logic [CW-1:0] TRIP = CW'(MISS_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            miss_q <= 1'b0;
        end else if (gps_evt) begin
            cnt_q  <= '0;
            miss_q <= 1'b0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == TRIP) miss_q <= 1'b1;
        end
    end

    assign pps_missing = miss_q;

    // R7
    miss_clear_chk: assert property (@(posedge clk) disable iff (rst)
        gps_evt |=> !pps_missing);

    // R7
    miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pps_missing && !gps_evt) |=> pps_missing);

endmodule

// File: rtl/gps_pps_phase_detector.sv
module gps_pps_phase_detector
    import gpsphase_pkg::*;
#(
    parameter int DIV_COUNT    = 10_000_000,
    parameter int TICKS_PER_EN = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    gps_pps_in,
    input  logic                    osc_en,
    input  logic                    align_load,
    output logic                    local_pps,
    output logic signed [ERR_W-1:0] phase_err,
    output logic                    err_valid,
    output logic                    pps_missing
);
    localparam int SECOND_TICKS = DIV_COUNT * TICKS_PER_EN;
    localparam int HALF_TICKS   = SECOND_TICKS / 2;
    localparam int MISS_TICKS   = SECOND_TICKS + HALF_TICKS;

    logic gps_rise;

    pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pps_async (gps_pps_in),
        .rise      (gps_rise)
    );

    pps_local_div #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk        (clk),
        .rst        (rst),
        .osc_en     (osc_en),
        .align_load (align_load),
        .gps_rise   (gps_rise),
        .local_pps  (local_pps)
    );

    pps_phase_meter #(.HALF_TICKS(HALF_TICKS), .LAT(SYNC_STAGES - 1)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .gps_evt   (gps_rise),
        .local_evt (local_pps),
        .phase_err (phase_err),
        .err_valid (err_valid)
    );

    pps_loss_watch #(.MISS_TICKS(MISS_TICKS)) u_loss (
        .clk         (clk),
        .rst         (rst),
        .gps_evt     (gps_rise),
        .pps_missing (pps_missing)
    );

    // R2
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!local_pps && !err_valid && !pps_missing));

endmodule

// File: tb/test_gps_pps_phase_detector.sv
module test_gps_pps_phase_detector;
    localparam int DIV  = 50;
    localparam int TPE  = 4;
    localparam int SYN  = 2;
    localparam int SEC  = DIV * TPE;
    localparam int MISS = SEC + SEC / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gps_in = 1'b0;
    logic osc_en = 1'b0;
    logic align_load = 1'b0;
    logic local_pps;
    logic signed [31:0] phase_err;
    logic err_valid;
    logic pps_missing;

    gps_pps_phase_detector #(
        .DIV_COUNT(DIV), .TICKS_PER_EN(TPE), .SYNC_STAGES(SYN)
    ) i_gps_pps_phase_detector (
        .clk(clk), .rst(rst), .gps_pps_in(gps_in), .osc_en(osc_en),
        .align_load(align_load), .local_pps(local_pps), .phase_err(phase_err),
        .err_valid(err_valid), .pps_missing(pps_missing)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    int gps_at = -100000;
    int last_local = -1;
    int local_seen = 0;
    int nvalid = 0;
    int last_err = 0;
    int last_vcyc = -1;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic tick();
        @(posedge clk);
        cyc++;
        @(negedge clk);
        if (local_pps) begin
            last_local = cyc;
            local_seen++;
        end
        if (err_valid) begin
            nvalid++;
            last_err = phase_err;
            last_vcyc = cyc;
        end
        osc_en = ((cyc + 1) % TPE == 0);
        gps_in = (cyc + 1 >= gps_at) && (cyc + 1 < gps_at + 8);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_to(input int c);
        while (cyc < c) tick();
    endtask

    function automatic int exp_vcyc(input int g, input int l);
        int e = g + SYN - 1;
        return ((e > l) ? e : l) + 1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int a, t, d, v0, n0, g, f, lr, base, s;
        s = $urandom(32'h5eed);
        repeat (5) tick();
        // R2 reset state
        chk(local_pps == 1'b0, "R2 local_pps in reset", local_pps, 0);
        chk(err_valid == 1'b0, "R2 err_valid in reset", err_valid, 0);
        chk(pps_missing == 1'b0, "R2 pps_missing in reset", pps_missing, 0);
        rst = 1'b0;
        a = 0;
        while (local_seen < 1 && a < 2000) begin tick(); a++; end
        chk(local_seen == 1, "R2 first local pulse after release", local_seen, 1);
        a = last_local;
        while (local_seen < 2 && cyc < a + 2 * SEC) tick();
        // R1 free-running period
        chk(last_local - a == SEC, "R1 local period", last_local - a, SEC);

        t = last_local;
        for (int k = 0; k < 26; k++) begin
            case (k)
                0: d = 0;
                1: d = 5;
                2: d = -7;
                3: d = 1;
                4: d = -1;
                5: d = 90;
                6: d = -90;
                default: d = int'($urandom_range(80)) - 40;
            endcase
            t = t + SEC;
            gps_at = t + d;
            v0 = nvalid;
            run_to(t + 100);
            chk(last_local == t, "R1 local pulse position", last_local, t);
            chk(nvalid - v0 == 1, "R5 one report per pair", nvalid - v0, 1);
            if (d >= 0)
                chk(last_err == d, "R3 lagging error", last_err, d);
            else
                chk(last_err == d, "R4 leading error", last_err, d);
            chk(last_vcyc == exp_vcyc(t + d, t), "R5 valid timing",
                last_vcyc, exp_vcyc(t + d, t));
            if (k > 0)
                chk(pps_missing == 1'b0, "R7 flag low with reference", pps_missing, 0);
        end

        // R9 realignment
        align_load = 1'b1;
        tick();
        align_load = 1'b0;
        g = t + 330;
        gps_at = g;
        v0 = nvalid;
        run_to(g + SYN + 3);
        chk(last_local == g + SYN, "R9 realigned pulse", last_local, g + SYN);
        chk(nvalid - v0 == 1, "R9 report count", nvalid - v0, 1);
        chk(last_err == -SYN, "R9 realign error", last_err, -SYN);
        f = g + SYN + 1;
        while (f % TPE != 0) f++;
        lr = f + (DIV - 1) * TPE;
        n0 = local_seen;
        run_to(lr + 1);
        chk(last_local == lr, "R9 next pulse after restart", last_local, lr);
        chk(local_seen - n0 == 1, "R9 single pulse in restart second", local_seen - n0, 1);

        // R7 / R8 / R6 reference absent
        v0 = nvalid;
        run_to(g + SYN + MISS - 1);
        chk(pps_missing == 1'b0, "R7 flag before limit", pps_missing, 0);
        tick();
        chk(pps_missing == 1'b1, "R7 flag at limit", pps_missing, 1);
        run_to(g + 700);
        chk(pps_missing == 1'b1, "R7 flag held", pps_missing, 1);
        chk(nvalid == v0, "R8 no report without reference", nvalid - v0, 0);
        chk(nvalid == v0, "R6 unmatched local windows dropped", nvalid - v0, 0);

        // R7 recovery
        base = lr;
        while (base <= cyc + 20) base += SEC;
        gps_at = base + 10;
        v0 = nvalid;
        run_to(base + 20);
        chk(nvalid - v0 == 1, "R3 report after recovery", nvalid - v0, 1);
        chk(last_err == 10, "R3 error after recovery", last_err, 10);
        chk(pps_missing == 1'b0, "R7 flag cleared by edge", pps_missing, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule